// File: doc/BRIEF.md
# Machine interrupt enable, pending and vectoring unit

This block is the interrupt front end of a machine-mode core. It owns the interrupt enable register and derives the read-only pending view from the live interrupt lines. The lines are software, timer, external, a bank of fast local lines and one non-maskable line, and all of them are level-sensitive. Each cycle it chooses the winning request and presents a take request, the cause ID of the winner and the vectored fetch address. Saving the program counter, the trap CSRs and the pipeline flush belong to the core and are not part of this block.

Software reaches the two registers through a plain CSR port. Writes take effect at the clock edge and reads are combinational. The core supplies the global enable bit, a debug-mode flag and a ready flag that marks an instruction boundary. It also supplies the vector base with its low byte left off, because the base is 256-byte aligned.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the enable register (CSR address 0x304) and the pending register (CSR address 0x344) both read zero, and take_irq_o is low.
- R2: A write to address 0x304 stores only the implemented bits: bit 3 software, bit 7 timer, bit 11 external, and bits 16 to 30 for fast line x at bit x+16. Every other bit ignores the write and reads zero, so writing all ones reads back 0x7FFF0888.
- R3: Address 0x344 reads input line AND enable, using the R2 bit layout. A write to 0x344 changes neither register. Any other address reads zero.
- R4: A maskable interrupt is taken only when global_en_i is high and its enable bit is set.
- R5: When several requests are candidates, the highest ID wins. The IDs are 3 software, 7 timer, 11 external, 16+x fast line x, and 31 non-maskable.
- R6: The non-maskable line takes ID 31 whatever the global and individual enables are. It never shows in the pending register, and its target is base plus 0x7C.
- R7: irq_target_o is the base in bits 31:8 with four times the cause ID in bits 7:0. With no candidate, the cause is 0 and the target is the bare base.
- R8: While debug_mode_i is high, no interrupt is taken, including the non-maskable one.
- R9: take_irq_o is raised only in a cycle where core_ready_i is high.
- R10: The lines are level-sensitive and unlatched. take_irq_o follows the lines in the same cycle and drops as soon as the winning line drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for csr_addr_i |
| global_en_i | input | 1 | Global machine interrupt enable |
| debug_mode_i | input | 1 | Core is in debug mode |
| core_ready_i | input | 1 | Core is at an instruction boundary |
| vec_base_i | input | 24 | Vector base, bits 31:8 |
| irq_sw_i | input | 1 | Software interrupt line |
| irq_tmr_i | input | 1 | Timer interrupt line |
| irq_ext_i | input | 1 | External interrupt line |
| irq_fast_i | input | 15 | Fast local interrupt lines |
| irq_nmi_i | input | 1 | Non-maskable interrupt line |
| take_irq_o | output | 1 | Take-interrupt request |
| irq_cause_o | output | 5 | Cause ID of the winning request |
| irq_target_o | output | 32 | Vectored jump address |

## Verification
The bench goes after the cases a careless implementation gets wrong. One is a write of all ones to the enable register; a design without the implemented-bit mask would read back stray bits. Another is a write to the pending address; a design that decodes it as the enable register would change the enable state. The non-maskable line is driven with every enable cleared, and a design that gates it or reports it as pending would either miss the take or show bit 31. The bench also sweeps each line on its own across different bases, to catch wrong bit positions and vector offsets. Mixed patterns under debug mode and with ready low check that the priority pick and the suppression rules are combined correctly.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned XLEN      = 32;
  localparam int unsigned CAUSE_W   = 5;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned VEC_ALIGN = 8;
  localparam int unsigned ID_SW     = 3;
  localparam int unsigned ID_TMR    = 7;
  localparam int unsigned ID_EXT    = 11;
  localparam int unsigned FAST_LO   = 16;
  localparam int unsigned ID_NMI    = 31;
  localparam logic [ADDR_W-1:0] CSR_IE = 12'h304;
  localparam logic [ADDR_W-1:0] CSR_IP = 12'h344;

  function automatic logic [XLEN-1:0] ie_mask(int unsigned nfast);
    logic [XLEN-1:0] m;
    m = '0;
    m[ID_SW]  = 1'b1;
    m[ID_TMR] = 1'b1;
    m[ID_EXT] = 1'b1;
    for (int unsigned i = 0; i < nfast; i++) m[FAST_LO+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_line_map.sv
module irq_line_map
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_FAST = 15
) (
  input  logic                irq_sw_i,
  input  logic                irq_tmr_i,
  input  logic                irq_ext_i,
  input  logic [NUM_FAST-1:0] irq_fast_i,
  output logic [XLEN-1:0]     lines_o
);
  always_comb begin
    lines_o         = '0;
    lines_o[ID_SW]  = irq_sw_i;
    lines_o[ID_TMR] = irq_tmr_i;
    lines_o[ID_EXT] = irq_ext_i;
  end

  // fast line x lands on ID x+16; assigned in a second pass to keep one driver
  logic [XLEN-1:0] fast_pos;
  generate
    for (genvar x = 0; x < XLEN; x++) begin : g_pos
      if (x >= FAST_LO && x < FAST_LO + NUM_FAST) begin : g_fast
        assign fast_pos[x] = irq_fast_i[x-FAST_LO];
      end else begin : g_none
        assign fast_pos[x] = 1'b0;
      end
    end
  endgenerate

  logic [XLEN-1:0] lines_all;
  assign lines_all = lines_o | fast_pos;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_vec_pkg::*;
#(
  parameter logic [XLEN-1:0] MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (we_i) en_o <= wdata_i & MASK;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N   = 32,
  parameter int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDW-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int unsigned i = 0; i < N; i++) begin
      if (req_i[i]) id_o = IDW'(i);  // later index overrides: highest wins
    end
    valid_o = |req_i;
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_FAST = 15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         csr_addr_i,
  input  logic                      csr_we_i,
  input  logic [XLEN-1:0]           csr_wdata_i,
  output logic [XLEN-1:0]           csr_rdata_o,
  input  logic                      global_en_i,
  input  logic                      debug_mode_i,
  input  logic                      core_ready_i,
  input  logic [XLEN-1:VEC_ALIGN]   vec_base_i,
  input  logic                      irq_sw_i,
  input  logic                      irq_tmr_i,
  input  logic                      irq_ext_i,
  input  logic [NUM_FAST-1:0]       irq_fast_i,
  input  logic                      irq_nmi_i,
  output logic                      take_irq_o,
  output logic [CAUSE_W-1:0]        irq_cause_o,
  output logic [XLEN-1:0]           irq_target_o
);
  localparam logic [XLEN-1:0] EN_MASK = ie_mask(NUM_FAST);
  localparam int unsigned     OFS_W   = VEC_ALIGN - CAUSE_W - 2;

  logic [XLEN-1:0] lines, en_q, pend, req;
  logic            ie_we, cand;

  irq_line_map #(.NUM_FAST(NUM_FAST)) u_map (
    .irq_sw_i   (irq_sw_i),
    .irq_tmr_i  (irq_tmr_i),
    .irq_ext_i  (irq_ext_i),
    .irq_fast_i (irq_fast_i),
    .lines_o    ()
  );
  assign lines = u_map.lines_all;

  assign ie_we = csr_we_i && (csr_addr_i == CSR_IE);

  irq_enable_reg #(.MASK(EN_MASK)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ie_we),
    .wdata_i (csr_wdata_i),
    .en_o    (en_q)
  );

  assign pend = lines & en_q;

  always_comb begin
    req         = global_en_i ? pend : '0;
    req[ID_NMI] = irq_nmi_i;  // bypasses both enable levels
  end

  irq_prio_pick #(.N(XLEN), .IDW(CAUSE_W)) u_pick (
    .req_i   (req),
    .valid_o (cand),
    .id_o    (irq_cause_o)
  );

  assign take_irq_o   = cand && core_ready_i && !debug_mode_i;
  assign irq_target_o = {vec_base_i, {OFS_W{1'b0}}, irq_cause_o, 2'b00};

  always_comb begin
    unique case (csr_addr_i)
      CSR_IE:  csr_rdata_o = en_q;
      CSR_IP:  csr_rdata_o = pend;
      default: csr_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
  import irq_vec_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       csr_addr_i,
  input logic                    csr_we_i,
  input logic [XLEN-1:0]         csr_wdata_i,
  input logic                    global_en_i,
  input logic                    debug_mode_i,
  input logic                    core_ready_i,
  input logic [XLEN-1:VEC_ALIGN] vec_base_i,
  input logic                    irq_nmi_i,
  input logic                    take_irq_o,
  input logic [CAUSE_W-1:0]      irq_cause_o,
  input logic [XLEN-1:0]         irq_target_o,
  input logic [XLEN-1:0]         en_q,
  input logic [XLEN-1:0]         pend
);
  localparam logic [XLEN-1:0] IMPL = 32'h7FFF_0888;

  a_r2_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q & ~IMPL) == '0);

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_addr_i == CSR_IE) |=> en_q == ($past(csr_wdata_i) & IMPL));

  a_r3_pend_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~en_q) == '0) && !pend[ID_NMI]);

  a_r4_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!global_en_i && !irq_nmi_i) |-> !take_irq_o);

  a_r6_nmi_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_nmi_i && core_ready_i && !debug_mode_i) |->
      (take_irq_o && irq_cause_o == 5'd31));

  a_r7_target_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (irq_target_o[XLEN-1:VEC_ALIGN] == vec_base_i &&
                    irq_target_o[VEC_ALIGN-1:0] == {1'b0, irq_cause_o, 2'b00}));

  a_r8_debug_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    debug_mode_i |-> !take_irq_o);

  a_r9_ready_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_ready_i |-> !take_irq_o);
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (.*);

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] csr_addr_i = 12'h304;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [31:0] csr_rdata_o;
  logic        global_en_i = 1'b0, debug_mode_i = 1'b0, core_ready_i = 1'b1;
  logic [23:0] vec_base_i = 24'h000100;
  logic        irq_sw_i = 1'b0, irq_tmr_i = 1'b0, irq_ext_i = 1'b0, irq_nmi_i = 1'b0;
  logic [14:0] irq_fast_i = '0;
  logic        take_irq_o;
  logic [4:0]  irq_cause_o;
  logic [31:0] irq_target_o;

  int unsigned n_vec = 0, n_bad = 0;
  bit          done = 1'b0;
  logic [31:0] ref_en = '0;

  always #2.5 clk_i = ~clk_i;

  irq_vector_unit u_irq_vector_unit (.*);

  // reference register state
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_en <= '0;
    else if (csr_we_i && csr_addr_i == 12'h304) ref_en <= csr_wdata_i & 32'h7FFF_0888;
  end

  function automatic logic [31:0] ref_lines();
    logic [31:0] v = '0;
    v[3] = irq_sw_i; v[7] = irq_tmr_i; v[11] = irq_ext_i;
    for (int x = 0; x < 15; x++) v[16+x] = irq_fast_i[x];
    return v;
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] pnd = ref_lines() & ref_en;
    logic [31:0] rd;
    int          id = -1;
    logic        tk;
    if (irq_nmi_i) id = 31;
    else if (global_en_i)
      for (int i = 31; i >= 0; i--) if (id < 0 && pnd[i]) id = i;
    tk = (id >= 0) && core_ready_i && !debug_mode_i;
    if (id < 0) id = 0;
    rd = (csr_addr_i == 12'h304) ? ref_en : (csr_addr_i == 12'h344) ? pnd : 32'h0;
    cmp(tag, "take", {31'b0, take_irq_o}, {31'b0, tk});
    cmp(tag, "cause", {27'b0, irq_cause_o}, 32'(id));
    cmp(tag, "target", irq_target_o, {vec_base_i, 8'(id * 4)});
    cmp(tag, "rdata", csr_rdata_o, rd);
  endtask

  task automatic tick(string tag);
    @(posedge clk_i);
    @(negedge clk_i);
    check_all(tag);
    csr_we_i = 1'b0;
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d, string tag);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1;
    tick(tag);
  endtask

  initial begin
    logic [31:0] lfsr = 32'hACE1_2357;
    // R1: reset state
    tick("R1");
    csr_addr_i = 12'h344; tick("R1");
    rst_ni = 1'b1; tick("R1");
    // R2: only implemented bits hold
    csr_wr(12'h304, 32'hFFFF_FFFF, "R2");
    tick("R2");
    csr_wr(12'h304, 32'h8000_0777, "R2");
    tick("R2");
    // R3: pending address is read-only; unknown address reads zero
    csr_wr(12'h304, 32'hFFFF_FFFF, "R3");
    csr_wr(12'h344, 32'h0000_0000, "R3");
    tick("R3");
    irq_tmr_i = 1'b1; irq_fast_i = 15'h4001; csr_addr_i = 12'h344; tick("R3");
    csr_addr_i = 12'h300; tick("R3");
    csr_addr_i = 12'h344;
    // R4: global enable gates maskable lines
    global_en_i = 1'b0; tick("R4");
    global_en_i = 1'b1; tick("R4");
    csr_wr(12'h304, 32'h0000_0080, "R4");
    tick("R4");
    // R5: highest ID wins
    csr_wr(12'h304, 32'hFFFF_FFFF, "R5");
    irq_sw_i = 1'b1; irq_ext_i = 1'b1; irq_fast_i = 15'h0000; tick("R5");
    irq_fast_i = 15'h0006; tick("R5");
    // R7: each line alone over different bases
    irq_sw_i = 0; irq_tmr_i = 0; irq_ext_i = 0; irq_fast_i = '0;
    for (int k = 0; k < 18; k++) begin
      vec_base_i = 24'h80_0000 + 24'(k * 24'h0101);
      if (k == 0) irq_sw_i = 1; else if (k == 1) irq_tmr_i = 1;
      else if (k == 2) irq_ext_i = 1; else irq_fast_i = 15'(1 << (k - 3));
      tick("R7");
      irq_sw_i = 0; irq_tmr_i = 0; irq_ext_i = 0; irq_fast_i = '0;
    end
    tick("R7");
    // R6: non-maskable line bypasses enables, not pending
    global_en_i = 1'b0;
    csr_wr(12'h304, 32'h0, "R6");
    irq_nmi_i = 1'b1; tick("R6");
    csr_wr(12'h304, 32'hFFFF_FFFF, "R6");
    global_en_i = 1'b1; irq_fast_i = 15'h7FFF; tick("R6");
    // R8: debug mode blocks everything
    debug_mode_i = 1'b1; tick("R8");
    irq_nmi_i = 1'b0; tick("R8");
    debug_mode_i = 1'b0;
    // R9: ready gating
    core_ready_i = 1'b0; tick("R9");
    irq_nmi_i = 1'b1; tick("R9");
    core_ready_i = 1'b1; irq_nmi_i = 1'b0; tick("R9");
    // R10: level-sensitive, drops at once
    irq_fast_i = 15'h0000; irq_ext_i = 1'b1; tick("R10");
    irq_ext_i = 1'b0; tick("R10");
    // R5: mixed patterns
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      {irq_sw_i, irq_tmr_i, irq_ext_i} = lfsr[2:0];
      irq_fast_i   = lfsr[17:3] & {15{lfsr[18]}};
      irq_nmi_i    = lfsr[19] & lfsr[20] & lfsr[21];
      global_en_i  = lfsr[22] | lfsr[23];
      debug_mode_i = lfsr[24] & lfsr[25] & lfsr[26];
      core_ready_i = lfsr[27] | lfsr[28];
      vec_base_i   = lfsr[31:8];
      csr_addr_i   = lfsr[29] ? 12'h304 : 12'h344;
      if (lfsr[30] && lfsr[4]) csr_wr(12'h304, {lfsr[15:0], lfsr[31:16]}, "R5");
      else tick("R5");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule